// File: doc/BRIEF.md
# Configurable SPI Master/Slave Port

This block is one serial peripheral interface (SPI) port. A set of static control inputs chooses whether it runs as bus master or as slave, where the clock rests, on which clock transition the outgoing data moves, and whether each transfer is one byte or one 16-bit word. The host side is a parallel word with a start strobe. The result comes back as a parallel word with a single-cycle done pulse, and a busy flag covers the whole transfer. On the bus side it has a clock, a data output, a data input and an active-low select line, and the two driven pins each have their own output enable.

As master, the port makes its serial clock from the system clock with a programmable divider. It can sample the incoming bit halfway through each bit period or at its end. As slave, it brings the bus clock, data and select into the system clock domain through a short synchronizer and acts on the edges it finds there. It always samples on the transition opposite to the one that moves its output. A transfer is armed by the start strobe. When select gating is on, bus edges count only while the select line is low. Either driven pin can be released by its own disable input.

Top module: `spi_port`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0, `rx_word` is 0 and `sck_oe` is 0, because every control input at 0 means slave mode.
- R2: In master mode, `sck_o` sits at the `cfg_ckp` level whenever no transfer is running. Level 1 means idle high and active low; level 0 means idle low and active high.
- R3: With `cfg_cke`=1, output data moves on the active-to-idle clock transition, so the first half of each master bit period is idle. With `cfg_cke`=0 it moves on the idle-to-active transition, so the first half is active. In master mode `sdo_o` changes only at the end of a bit period.
- R4: In master mode, `cfg_smp`=0 samples `sdi_i` at the end of the first half of each bit period, and `cfg_smp`=1 samples it at the end of the bit period.
- R5: In slave mode `cfg_smp` has no effect. Input is taken on the bus clock transition opposite to the output-change transition.
- R6: `cfg_wide`=1 gives 16-bit transfers and `cfg_wide`=0 gives 8-bit transfers. In byte mode the low byte of `tx_word` is sent and the received byte sits in bits 7:0 of `rx_word`, with bits 15:8 at 0.
- R7: While `cfg_sdo_off` is 1, `sdo_oe` is 0.
- R8: `sck_oe` is 1 only in master mode with `cfg_sck_off` at 0.
- R9: With `cfg_ss_en`=1, a slave ignores bus clock edges and holds `sdo_oe` low while `ss_n_i` is high. With `cfg_ss_en`=0, `ss_n_i` has no effect.
- R10: Bits go out and come in most significant bit first. `done` is high for exactly one cycle, at the end of the transfer, and `rx_word` holds the received word from that cycle on.
- R11: A master half bit period lasts `clk_div`+1 system clocks, so a transfer keeps `busy` high for 2·bits·(`clk_div`+1) cycles.
- R12: `busy` rises on an accepted start and falls in the cycle `done` is asserted. A start that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_ckp | input | 1 | Clock idle level |
| cfg_cke | input | 1 | 1 = output moves on active-to-idle transition, 0 = on idle-to-active transition |
| cfg_smp | input | 1 | Master sample point: 0 = mid bit, 1 = end of bit |
| cfg_wide | input | 1 | 1 = 16-bit transfer, 0 = 8-bit transfer |
| cfg_sdo_off | input | 1 | Release the data output pin |
| cfg_sck_off | input | 1 | Release the clock pin in master mode |
| cfg_ss_en | input | 1 | Use the select line in slave mode |
| clk_div | input | DIV_W | Master half-period length minus one |
| tx_word | input | 16 | Word to send, captured on start |
| start | input | 1 | Start strobe |
| rx_word | output | 16 | Last received word |
| done | output | 1 | One-cycle end-of-transfer pulse |
| busy | output | 1 | Transfer in progress |
| sck_i | input | 1 | Bus clock input (slave) |
| sck_o | output | 1 | Bus clock output (master) |
| sck_oe | output | 1 | Clock pin output enable |
| sdo_o | output | 1 | Serial data output |
| sdo_oe | output | 1 | Data pin output enable |
| sdi_i | input | 1 | Serial data input |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
In master runs, the bench model of the far end drives one word during the first half of every bit period and a different word during the second half. The received word therefore shows directly which sample point is in effect. Both clock polarities, both edge choices, both widths and several divider values are used, and the length of `busy` and the resting clock level are measured. In slave runs, the bench master drives the complement of each bit between the sample edge and the change edge, so any sampling on the wrong transition corrupts the word. A burst of bus clocks sent with select high, followed by a clean transfer, shows whether deselected edges were counted. A second start during a transfer shows whether it was taken.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned BYTE_W = WORD_W / 2;
    localparam int unsigned CNT_W  = $clog2(2 * WORD_W);

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic master;
        logic ckp;
        logic cke;
        logic smp;
        logic wide;
        logic sdo_off;
        logic sck_off;
        logic ss_en;
    } spi_cfg_t;

    function automatic int unsigned bits_of(input logic wide);
        return wide ? WORD_W : BYTE_W;
    endfunction

    // Byte transfers are shifted out from the top of the register.
    function automatic word_t align_tx(input word_t v, input logic wide);
        return wide ? v : {v[BYTE_W-1:0], {BYTE_W{1'b0}}};
    endfunction

    // Received bytes are returned right-justified and zero-extended.
    function automatic word_t align_rx(input word_t v, input logic wide);
        return wide ? v : {{BYTE_W{1'b0}}, v[BYTE_W-1:0]};
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
    import spi_port_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  spi_cfg_t         cfg,
    input  logic [DIV_W-1:0] div,
    input  logic             start,
    input  word_t            tx,
    input  logic             sdi,
    output logic             sck_lvl,
    output logic             sdo_bit,
    output logic             busy,
    output logic             done,
    output word_t            rx
);
    logic [CNT_W-1:0] half_q;
    logic [DIV_W-1:0] dcnt_q;
    word_t            txsh_q, rxsh_q, rx_q, rx_nxt;
    logic             busy_q, done_q, tick, last_half;

    assign tick      = busy_q && (dcnt_q == div);
    assign last_half = (half_q == CNT_W'(2 * bits_of(cfg.wide) - 1));
    assign rx_nxt    = {rxsh_q[WORD_W-2:0], sdi};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            half_q <= '0;
            dcnt_q <= '0;
            txsh_q <= '0;
            rxsh_q <= '0;
            rx_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    half_q <= '0;
                    dcnt_q <= '0;
                    txsh_q <= align_tx(tx, cfg.wide);
                    rxsh_q <= '0;
                end
            end else if (tick) begin
                dcnt_q <= '0;
                half_q <= half_q + 1'b1;
                if (!half_q[0]) begin
                    if (!cfg.smp) rxsh_q <= rx_nxt;
                end else begin
                    if (cfg.smp) rxsh_q <= rx_nxt;
                    txsh_q <= {txsh_q[WORD_W-2:0], 1'b0};
                    if (last_half) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                        rx_q   <= align_rx(cfg.smp ? rx_nxt : rxsh_q, cfg.wide);
                    end
                end
            end else begin
                dcnt_q <= dcnt_q + 1'b1;
            end
        end
    end

    // First half of a bit is idle when output moves on the trailing transition.
    assign sck_lvl = busy_q ? (cfg.ckp ^ (half_q[0] ? cfg.cke : ~cfg.cke)) : cfg.ckp;
    assign sdo_bit = txsh_q[WORD_W-1];
    assign busy    = busy_q;
    assign done    = done_q;
    assign rx      = rx_q;

    // R10
    m_done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    // R12
    m_busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> done_q);
    // R6
    m_half_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (half_q <= CNT_W'(2 * bits_of(cfg.wide) - 1)));
    // R11
    m_div_range_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $stable(div)) |-> (dcnt_q <= div));
    // R3
    m_sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q) && !$past(tick)) |-> $stable(sdo_bit));
endmodule

// File: rtl/spi_slave_core.sv
module spi_slave_core
    import spi_port_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  spi_cfg_t cfg,
    input  logic     start,
    input  word_t    tx,
    input  logic     sck_s,
    input  logic     sdi_s,
    input  logic     ss_s,
    output logic     sel,
    output logic     sdo_bit,
    output logic     busy,
    output logic     done,
    output word_t    rx
);
    logic [CNT_W-1:0] cnt_q;
    word_t            txsh_q, rxsh_q, rx_q, rx_nxt;
    logic             sck_q, busy_q, done_q, first_q;
    logic             lead, trail, samp, chg, last_bit;

    assign lead     = (sck_q == cfg.ckp) && (sck_s != cfg.ckp);
    assign trail    = (sck_q != cfg.ckp) && (sck_s == cfg.ckp);
    assign samp     = cfg.cke ? lead  : trail;
    assign chg      = cfg.cke ? trail : lead;
    assign sel      = !cfg.ss_en || !ss_s;
    assign last_bit = (cnt_q == CNT_W'(bits_of(cfg.wide) - 1));
    assign rx_nxt   = {rxsh_q[WORD_W-2:0], sdi_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q   <= 1'b0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            first_q <= 1'b0;
            cnt_q   <= '0;
            txsh_q  <= '0;
            rxsh_q  <= '0;
            rx_q    <= '0;
        end else begin
            sck_q  <= sck_s;
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q  <= 1'b1;
                    first_q <= 1'b1;
                    cnt_q   <= '0;
                    txsh_q  <= align_tx(tx, cfg.wide);
                    rxsh_q  <= '0;
                end
            end else if (sel) begin
                if (samp) begin
                    rxsh_q  <= rx_nxt;
                    cnt_q   <= cnt_q + 1'b1;
                    first_q <= 1'b0;
                    if (last_bit) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                        rx_q   <= align_rx(rx_nxt, cfg.wide);
                    end
                end else if (chg && !first_q) begin
                    txsh_q <= {txsh_q[WORD_W-2:0], 1'b0};
                end
            end
        end
    end

    assign sdo_bit = txsh_q[WORD_W-1];
    assign busy    = busy_q;
    assign done    = done_q;
    assign rx      = rx_q;

    // R10
    s_done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    // R12
    s_busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> done_q);
    // R6
    s_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q < CNT_W'(bits_of(cfg.wide))));
    // R9
    s_ss_block_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cfg.ss_en && ss_s) |=> $stable(cnt_q));
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_master,
    input  logic              cfg_ckp,
    input  logic              cfg_cke,
    input  logic              cfg_smp,
    input  logic              cfg_wide,
    input  logic              cfg_sdo_off,
    input  logic              cfg_sck_off,
    input  logic              cfg_ss_en,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              start,
    output logic [WORD_W-1:0] rx_word,
    output logic              done,
    output logic              busy,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              sdo_o,
    output logic              sdo_oe,
    input  logic              sdi_i,
    input  logic              ss_n_i
);
    spi_cfg_t cfg;
    logic [2:0] pins_s;
    logic       sck_s, sdi_s, ss_s;
    logic       m_sck, m_sdo, m_busy, m_done;
    logic       s_sel, s_sdo, s_busy, s_done;
    word_t      m_rx, s_rx;

    assign cfg = '{master: cfg_master, ckp: cfg_ckp, cke: cfg_cke, smp: cfg_smp,
                   wide: cfg_wide, sdo_off: cfg_sdo_off, sck_off: cfg_sck_off,
                   ss_en: cfg_ss_en};

    spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sck_i, sdi_i, ss_n_i}),
        .q   (pins_s)
    );
    assign {sck_s, sdi_s, ss_s} = pins_s;

    spi_master_core #(.DIV_W(DIV_W)) u_mst (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .div     (clk_div),
        .start   (start && cfg_master),
        .tx      (tx_word),
        .sdi     (sdi_i),
        .sck_lvl (m_sck),
        .sdo_bit (m_sdo),
        .busy    (m_busy),
        .done    (m_done),
        .rx      (m_rx)
    );

    spi_slave_core u_slv (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .start   (start && !cfg_master),
        .tx      (tx_word),
        .sck_s   (sck_s),
        .sdi_s   (sdi_s),
        .ss_s    (ss_s),
        .sel     (s_sel),
        .sdo_bit (s_sdo),
        .busy    (s_busy),
        .done    (s_done),
        .rx      (s_rx)
    );

    assign sck_o   = cfg_master ? m_sck  : cfg_ckp;
    assign sck_oe  = cfg_master && !cfg_sck_off;
    assign sdo_o   = cfg_master ? m_sdo  : s_sdo;
    assign sdo_oe  = !cfg_sdo_off && (cfg_master || s_sel);
    assign busy    = cfg_master ? m_busy : s_busy;
    assign done    = cfg_master ? m_done : s_done;
    assign rx_word = cfg_master ? m_rx   : s_rx;

    // R7
    sdo_release_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_sdo_off |-> !sdo_oe);
    // R8
    sck_slave_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_master |-> !sck_oe);
    // R9
    sdo_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_master && cfg_ss_en && ss_s) |-> !sdo_oe);
    // R2
    sck_rest_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_master && !m_busy && $past(!m_busy) && $stable(cfg_ckp)) |-> $stable(sck_o));
endmodule

// File: tb/sim_spi_port.sv
module sim_spi_port;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_master, cfg_ckp, cfg_cke, cfg_smp, cfg_wide;
    logic        cfg_sdo_off, cfg_sck_off, cfg_ss_en;
    logic [7:0]  clk_div;
    logic [15:0] tx_word, rx_word;
    logic        start, done, busy;
    logic        sck_i, sck_o, sck_oe, sdo_o, sdo_oe, sdi_i, ss_n_i;

    int n_chk = 0, n_fail = 0, n_done = 0;
    bit finished = 0;
    logic [15:0] exp_q [$];
    string       tag_q [$];

    // master-mode far-end model state
    bit          m_run = 0;
    int          mw, mslot, midx;
    logic        mprev, mh;
    logic [15:0] mA, mB, mcap;

    localparam int H = 10;

    always #2 clk = ~clk;

    spi_port u0 (
        .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_ckp(cfg_ckp),
        .cfg_cke(cfg_cke), .cfg_smp(cfg_smp), .cfg_wide(cfg_wide),
        .cfg_sdo_off(cfg_sdo_off), .cfg_sck_off(cfg_sck_off), .cfg_ss_en(cfg_ss_en),
        .clk_div(clk_div), .tx_word(tx_word), .start(start), .rx_word(rx_word),
        .done(done), .busy(busy), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .sdo_o(sdo_o), .sdo_oe(sdo_oe), .sdi_i(sdi_i), .ss_n_i(ss_n_i)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] fitw(input logic [15:0] v);
        return cfg_wide ? v : {8'h00, v[7:0]};
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            n_done++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected done", {16'h0, rx_word}, 32'h0);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(rx_word == e, t, {16'h0, rx_word}, {16'h0, e});
            end
        end
    end

    // far-end slave model for master runs: word A in the first half of a bit, word B in the second
    always @(negedge clk) begin
        if (m_run && busy) begin
            mh = sck_o ^ cfg_ckp ^ ~cfg_cke;
            if (mprev && !mh) mslot++;
            if (!mprev && mh) mcap = {mcap[14:0], sdo_o};
            mprev = mh;
            midx = mw - 1 - mslot;
            if (midx >= 0) sdi_i = mh ? mB[midx] : mA[midx];
        end
    end

    task automatic m_xfer(input logic [15:0] tx, input logic [15:0] a, input logic [15:0] b,
                          input bit glitch, input string tag);
        int cyc = 0;
        mw = cfg_wide ? 16 : 8;
        mA = a; mB = b; mslot = 0; mprev = 1'b0; mcap = '0; m_run = 1;
        exp_q.push_back(fitw(cfg_smp ? b : a));
        tag_q.push_back(tag);
        tx_word = tx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R3: level in the first half of the first bit
        chk(sck_o == (cfg_ckp ^ ~cfg_cke), "R3 first-half level", {31'h0, sck_o}, {31'h0, cfg_ckp ^ ~cfg_cke});
        // R8 / R7: pin enables during a master transfer
        chk(sck_oe == !cfg_sck_off, "R8 sck_oe master", {31'h0, sck_oe}, {31'h0, !cfg_sck_off});
        chk(sdo_oe == !cfg_sdo_off, "R7 sdo_oe master", {31'h0, sdo_oe}, {31'h0, !cfg_sdo_off});
        while (busy) begin
            cyc++;
            if (glitch && cyc == 5) begin
                tx_word = ~tx; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        m_run = 0;
        // R11
        chk(cyc == 2 * mw * (int'(clk_div) + 1), "R11 busy length", cyc, 2 * mw * (int'(clk_div) + 1));
        // R10: MSB-first output as seen by the far end
        chk(fitw(mcap) == fitw(tx), "R10 sent bits", {16'h0, fitw(mcap)}, {16'h0, fitw(tx)});
        // R2
        chk(sck_o == cfg_ckp, "R2 idle level", {31'h0, sck_o}, {31'h0, cfg_ckp});
        wcyc(2);
        chk(exp_q.size() == 0, "R12 single done", exp_q.size(), 0);
    endtask

    // bench acting as bus master toward the slave port
    task automatic s_bits(input logic [15:0] v, input int w, output logic [15:0] cap);
        cap = '0;
        for (int k = w - 1; k >= 0; k--) begin
            if (cfg_cke) begin
                sdi_i = v[k];
                wcyc(H);
                cap = {cap[14:0], sdo_o};
                sck_i = ~cfg_ckp;
                wcyc(H / 2);
                sdi_i = ~v[k];
                wcyc(H / 2);
                sck_i = cfg_ckp;
            end else begin
                sck_i = ~cfg_ckp;
                sdi_i = v[k];
                wcyc(H);
                cap = {cap[14:0], sdo_o};
                sck_i = cfg_ckp;
                wcyc(H / 2);
                sdi_i = ~v[k];
                wcyc(H / 2);
            end
        end
    endtask

    task automatic s_arm(input logic [15:0] tx);
        sck_i = cfg_ckp;
        wcyc(5);
        tx_word = tx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic s_xfer(input logic [15:0] tx, input logic [15:0] v, input string tag);
        logic [15:0] cap;
        int w = cfg_wide ? 16 : 8;
        int d0 = n_done;
        exp_q.push_back(fitw(v));
        tag_q.push_back(tag);
        s_arm(tx);
        chk(busy == 1'b1, "R12 busy after start", {31'h0, busy}, 32'h1);
        s_bits(v, w, cap);
        wcyc(3);
        chk(fitw(cap) == fitw(tx), "R10 slave sent bits", {16'h0, fitw(cap)}, {16'h0, fitw(tx)});
        chk(n_done == d0 + 1, "R12 slave done count", n_done, d0 + 1);
        chk(busy == 1'b0, "R12 busy cleared", {31'h0, busy}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] junk;
        int d0;
        rst = 1'b1;
        {cfg_master, cfg_ckp, cfg_cke, cfg_smp, cfg_wide} = '0;
        {cfg_sdo_off, cfg_sck_off, cfg_ss_en} = '0;
        clk_div = '0; tx_word = '0; start = 1'b0;
        sck_i = 1'b0; sdi_i = 1'b0; ss_n_i = 1'b1;
        wcyc(4);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(busy == 1'b0, "R1 busy", {31'h0, busy}, 32'h0);
        chk(done == 1'b0, "R1 done", {31'h0, done}, 32'h0);
        chk(rx_word == 16'h0, "R1 rx_word", {16'h0, rx_word}, 32'h0);
        chk(sck_oe == 1'b0, "R1 sck_oe", {31'h0, sck_oe}, 32'h0);

        // Master, idle low, output on trailing transition, mid sample, 16-bit
        cfg_master = 1; cfg_ckp = 0; cfg_cke = 1; cfg_smp = 0; cfg_wide = 1; clk_div = 8'd1;
        wcyc(2);
        m_xfer(16'hA53C, 16'h9B61, 16'h4E27, 0, "R4 master mid sample");

        // Master, idle high, output on leading transition, end sample, 8-bit
        cfg_ckp = 1; cfg_cke = 0; cfg_smp = 1; cfg_wide = 0; clk_div = 8'd2;
        wcyc(2);
        m_xfer(16'h77C5, 16'h0036, 16'h00B9, 0, "R4 master end sample byte R6");

        // Master, idle low, leading transition, mid sample, 8-bit, fastest divider
        cfg_ckp = 0; cfg_cke = 0; cfg_smp = 0; cfg_wide = 0; clk_div = 8'd0;
        wcyc(2);
        m_xfer(16'h1281, 16'h00E4, 16'h001B, 0, "R6 master byte mid");

        // Master with a second start during the transfer
        cfg_ckp = 1; cfg_cke = 1; cfg_smp = 1; cfg_wide = 1; clk_div = 8'd3;
        wcyc(2);
        m_xfer(16'hC0DE, 16'h2468, 16'hF00F, 1, "R12 start ignored while busy");

        // Master with both pins released
        cfg_sck_off = 1; cfg_sdo_off = 1; cfg_ckp = 0; cfg_cke = 1; cfg_smp = 0; clk_div = 8'd1;
        wcyc(2);
        m_xfer(16'h5A5A, 16'h3C96, 16'h0FF0, 0, "R7 R8 master pins released");
        cfg_sck_off = 0; cfg_sdo_off = 0;

        // Slave mode, smp set but must not matter
        cfg_master = 0; cfg_ckp = 0; cfg_cke = 1; cfg_smp = 1; cfg_wide = 1; cfg_ss_en = 0;
        ss_n_i = 1'b1;
        wcyc(2);
        chk(sck_oe == 1'b0, "R8 sck_oe slave", {31'h0, sck_oe}, 32'h0);
        s_xfer(16'h3E91, 16'hB4C7, "R5 slave sample edge, R9 ss ignored");

        // Slave, idle high, leading-transition output, byte
        cfg_ckp = 1; cfg_cke = 0; cfg_smp = 0; cfg_wide = 0;
        wcyc(2);
        s_xfer(16'h00A7, 16'h005D, "R5 R6 slave byte");

        // Slave with select in use: edges while deselected are ignored
        cfg_ckp = 0; cfg_cke = 1; cfg_wide = 0; cfg_ss_en = 1; ss_n_i = 1'b1;
        wcyc(4);
        d0 = n_done;
        s_arm(16'h0069);
        chk(sdo_oe == 1'b0, "R9 sdo_oe deselected", {31'h0, sdo_oe}, 32'h0);
        s_bits(16'h00FF, 8, junk);
        wcyc(4);
        chk(busy == 1'b1, "R9 still waiting", {31'h0, busy}, 32'h1);
        chk(n_done == d0, "R9 no done deselected", n_done, d0);
        ss_n_i = 1'b0;
        wcyc(4);
        chk(sdo_oe == 1'b1, "R9 sdo_oe selected", {31'h0, sdo_oe}, 32'h1);
        exp_q.push_back(16'h0093);
        tag_q.push_back("R9 word after select");
        s_bits(16'h0093, 8, junk);
        wcyc(3);
        chk(junk[7:0] == 8'h69, "R9 slave sent byte", {24'h0, junk[7:0]}, 32'h69);
        chk(n_done == d0 + 1, "R9 one done", n_done, d0 + 1);

        // Slave data pin released
        cfg_sdo_off = 1; cfg_ss_en = 0; ss_n_i = 1'b1;
        wcyc(4);
        chk(sdo_oe == 1'b0, "R7 sdo_oe slave released", {31'h0, sdo_oe}, 32'h0);
        cfg_sdo_off = 0;

        wcyc(4);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule